// File: doc/BRIEF.md
# Inter-Processor Interrupt Router

This block is a central dispatcher that carries interrupt messages between up to 256 interrupt-controller endpoints. Endpoints first enrol by identifier through a small registration port. One further identifier may be claimed once as the I/O interrupt source, which may send messages but never receives them. A sender then hands the router its source identifier together with a 64-bit command word. The router checks the request against the enrolment table and works out the set of targets from the destination shorthand. It then pulses the raise line of each target along with the 8-bit vector, serving one endpoint per clock.

A request runs to completion before the next is taken. While a request is in flight the router holds busy high and ready low. Every request ends with a single done pulse, and that pulse carries an error flag when the request was refused. Unsupported delivery modes, unknown senders and unknown physical destinations are all refused. None of the checks use priority arbitration or logical-destination matching.

Top module: `ipi_router`

## Requirements
- R1: Out of reset, no raise line is active, busy, done and err are low, req_ready is high, and the enrolment table and I/O-source slot are empty.
- R2: A registration pulse with reg_io=0 enrols reg_id and answers reg_ack one cycle later. Enrolling an identifier that is already present answers reg_err. With reg_io=1 the identifier is claimed as the I/O source, and a second claim while one is held answers reg_err. reg_ack and reg_err never rise together.
- R3: Command word fields are: vector at bits 7:0, delivery mode at 10:8, destination mode at bit 11 (0 = physical), shorthand at 19:18, and destination identifier at 63:56. All other bits are ignored. Shorthand 0 raises the vector on the endpoint named by the destination field.
- R4: Shorthand 1 (self) raises the vector on the sender's own endpoint. It is refused if the destination field equals the held I/O-source identifier, or if the sender is not an enrolled endpoint.
- R5: Shorthand 2 raises the vector on every enrolled endpoint. Endpoints are visited in ascending identifier order, with at most one raise line active per cycle.
- R6: Shorthand 3 behaves like shorthand 2 but skips the sender's own identifier.
- R7: Delivery modes 0 and 1 are delivered. Modes 2 through 7 end the request with done and err and raise nothing. A broadcast stops at the first endpoint it would deliver to. err is only ever asserted together with done.
- R8: A request is refused with done and err, and raises nothing, if the source identifier is 256 or more, or if it is neither an enrolled endpoint nor the held I/O source.
- R9: In physical destination mode, a destination field that names an unenrolled identifier refuses the request. In logical mode (bit 11 = 1) this check is skipped, and shorthand 0 raises the named identifier anyway.
- R10: A request is taken when req_valid and req_ready are both high. From the next cycle until done, busy is high and req_ready low, and any request presented in that window is ignored.
- R11: A point-to-point result (raise or error, together with done) appears on the first edge after the accepting edge. A broadcast visits identifier i on edge i+2 after acceptance, and done comes with the last identifier. A validation error appears on the first edge after acceptance.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_valid | input | 1 | Registration strobe |
| reg_id | input | 8 | Identifier to enrol or claim |
| reg_io | input | 1 | 1 claims the I/O-source slot, 0 enrols an endpoint |
| reg_ack | output | 1 | Registration accepted (one-cycle pulse) |
| reg_err | output | 1 | Registration refused (one-cycle pulse) |
| req_valid | input | 1 | Request strobe |
| req_ready | output | 1 | Router can take a request |
| req_src | input | 9 | Sender identifier (values of 256 and up are invalid) |
| req_cmd | input | 64 | Command word |
| raise | output | 256 | One-hot raise pulse per endpoint |
| raise_vec | output | 8 | Vector that accompanies the raise pulse |
| busy | output | 1 | Request in flight |
| done | output | 1 | Request finished (one-cycle pulse) |
| err | output | 1 | Qualifies done: the request was refused |

## Verification
The bench aims at the edges of the fan-out. It checks that shorthand 3 leaves out the sender, which a design that compared the wrong identifier would instead raise. It checks that the last identifier 255 is visited, which an off-by-one walk would drop. It checks that a broadcast with a bad delivery mode produces exactly one error and no raises, where a design that filtered per endpoint would leak raises. It checks the self shorthand aimed at the I/O-source identifier, the logical-mode bypass of the destination check, and senders at 300 or unenrolled, each of which a loose validation stage would let through as a raise. Requests presented mid-broadcast must leave no trace in the expected event queue. Every event is also matched against its exact cycle, so a design that inserted or dropped a pipeline stage fails.

// File: rtl/ipi_pkg.sv
`timescale 1ns/1ps
package ipi_pkg;
   localparam int ID_W      = 8;
   localparam int CMD_W     = 64;
   localparam int VEC_LSB   = 0;
   localparam int VEC_W     = 8;
   localparam int MODE_LSB  = 8;
   localparam int MODE_W    = 3;
   localparam int LOGIC_BIT = 11;
   localparam int SH_LSB    = 18;
   localparam int SH_W      = 2;
   localparam int DEST_LSB  = 56;

   typedef enum logic [SH_W-1:0] {
      SH_DEST   = 2'd0,
      SH_SELF   = 2'd1,
      SH_ALL    = 2'd2,
      SH_OTHERS = 2'd3
   } shorthand_e;

   typedef enum logic [MODE_W-1:0] {
      DM_FIXED  = 3'd0,
      DM_LOWPRI = 3'd1,
      DM_SMI    = 3'd2,
      DM_RSV3   = 3'd3,
      DM_NMI    = 3'd4,
      DM_INIT   = 3'd5,
      DM_START  = 3'd6,
      DM_RSV7   = 3'd7
   } dmode_e;

   typedef struct packed {
      logic [ID_W-1:0]  dest;
      shorthand_e       sh;
      logic             logical;
      dmode_e           mode;
      logic [VEC_W-1:0] vec;
   } ipi_cmd_t;
endpackage

// File: rtl/ipi_cmd_decode.sv
`timescale 1ns/1ps
module ipi_cmd_decode
   import ipi_pkg::*;
(
   input  logic [CMD_W-1:0] cmd,
   output ipi_cmd_t         fields,
   output logic             mode_ok
);
   logic unused_cmd_bits;

   assign fields.vec     = cmd[VEC_LSB +: VEC_W];
   assign fields.mode    = dmode_e'(cmd[MODE_LSB +: MODE_W]);
   assign fields.logical = cmd[LOGIC_BIT];
   assign fields.sh      = shorthand_e'(cmd[SH_LSB +: SH_W]);
   assign fields.dest    = cmd[DEST_LSB +: ID_W];

   assign mode_ok = (fields.mode == DM_FIXED) || (fields.mode == DM_LOWPRI);

   assign unused_cmd_bits = ^{cmd[DEST_LSB-1:SH_LSB+SH_W], cmd[SH_LSB-1:LOGIC_BIT+1]};
endmodule

// File: rtl/ipi_presence_table.sv
`timescale 1ns/1ps
module ipi_presence_table
   import ipi_pkg::*;
#(
   parameter int N_EP = 256
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  reg_valid,
   input  logic [ID_W-1:0]       reg_id,
   input  logic                  reg_io,
   output logic                  reg_ack,
   output logic                  reg_err,
   output logic [(1<<ID_W)-1:0]  pres_span,
   output logic                  io_set,
   output logic [ID_W-1:0]       io_id
);
   localparam logic [ID_W:0] EP_LIMIT = N_EP[ID_W:0];

   logic id_in_range;
   assign id_in_range = {1'b0, reg_id} < EP_LIMIT;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pres_span <= '0;
         io_set    <= 1'b0;
         io_id     <= '0;
         reg_ack   <= 1'b0;
         reg_err   <= 1'b0;
      end else begin
         reg_ack <= 1'b0;
         reg_err <= 1'b0;
         if (reg_valid) begin
            if (reg_io) begin
               if (io_set) begin
                  reg_err <= 1'b1;
               end else begin
                  io_set  <= 1'b1;
                  io_id   <= reg_id;
                  reg_ack <= 1'b1;
               end
            end else if (!id_in_range || pres_span[reg_id]) begin
               reg_err <= 1'b1;
            end else begin
               pres_span[reg_id] <= 1'b1;
               reg_ack           <= 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/ipi_fanout.sv
`timescale 1ns/1ps
module ipi_fanout
   import ipi_pkg::*;
#(
   parameter int N_EP = 256
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  req_take,
   input  logic [ID_W:0]         req_src,
   input  ipi_cmd_t              req_f,
   input  logic                  req_mode_ok,
   input  logic [(1<<ID_W)-1:0]  pres_span,
   input  logic                  io_set,
   input  logic [ID_W-1:0]       io_id,
   output logic                  busy,
   output logic                  fire,
   output logic [ID_W-1:0]       tgt,
   output logic [VEC_W-1:0]      vec,
   output logic                  done,
   output logic                  err
);
   localparam logic [ID_W:0]   EP_LIMIT = N_EP[ID_W:0];
   localparam logic [ID_W-1:0] LAST_ID  = ID_W'(N_EP - 1);

   typedef enum logic [1:0] {ST_IDLE, ST_CHECK, ST_WALK} st_e;

   st_e             state;
   logic [ID_W:0]   src_q;
   ipi_cmd_t        f_q;
   logic            ok_q;
   logic [ID_W-1:0] idx_q;

   logic            src_in_range, src_ep, src_io, chk_fail, uni_fail, is_bcast, elig;
   logic [ID_W-1:0] uni_tgt;

   always_comb begin
      src_in_range = src_q < EP_LIMIT;
      src_ep       = src_in_range && pres_span[src_q[ID_W-1:0]];
      src_io       = io_set && (src_q == {1'b0, io_id});
      chk_fail     = !(src_ep || src_io)
                   || (!f_q.logical && !pres_span[f_q.dest])
                   || ((f_q.sh == SH_SELF) && io_set && (f_q.dest == io_id));
      uni_tgt      = (f_q.sh == SH_SELF) ? src_q[ID_W-1:0] : f_q.dest;
      uni_fail     = ((f_q.sh == SH_SELF) && !src_ep) || !ok_q;
      is_bcast     = (f_q.sh == SH_ALL) || (f_q.sh == SH_OTHERS);
      elig         = pres_span[idx_q] && ((f_q.sh == SH_ALL) || ({1'b0, idx_q} != src_q));
   end

   assign busy = (state != ST_IDLE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= ST_IDLE;
         src_q <= '0;
         f_q   <= '0;
         ok_q  <= 1'b0;
         idx_q <= '0;
         fire  <= 1'b0;
         tgt   <= '0;
         vec   <= '0;
         done  <= 1'b0;
         err   <= 1'b0;
      end else begin
         fire <= 1'b0;
         done <= 1'b0;
         err  <= 1'b0;
         unique case (state)
            ST_IDLE: begin
               if (req_take) begin
                  src_q <= req_src;
                  f_q   <= req_f;
                  ok_q  <= req_mode_ok;
                  state <= ST_CHECK;
               end
            end
            ST_CHECK: begin
               if (chk_fail) begin
                  done  <= 1'b1;
                  err   <= 1'b1;
                  state <= ST_IDLE;
               end else if (is_bcast) begin
                  idx_q <= '0;
                  state <= ST_WALK;
               end else begin
                  done  <= 1'b1;
                  state <= ST_IDLE;
                  if (uni_fail) begin
                     err <= 1'b1;
                  end else begin
                     fire <= 1'b1;
                     tgt  <= uni_tgt;
                     vec  <= f_q.vec;
                  end
               end
            end
            ST_WALK: begin
               if (elig && !ok_q) begin
                  done  <= 1'b1;
                  err   <= 1'b1;
                  state <= ST_IDLE;
               end else begin
                  if (elig) begin
                     fire <= 1'b1;
                     tgt  <= idx_q;
                     vec  <= f_q.vec;
                  end
                  if (idx_q == LAST_ID) begin
                     done  <= 1'b1;
                     state <= ST_IDLE;
                  end else begin
                     idx_q <= idx_q + 1'b1;
                  end
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/ipi_router.sv
`timescale 1ns/1ps
module ipi_router
   import ipi_pkg::*;
#(
   parameter int N_EP = 256
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_valid,
   input  logic [ID_W-1:0]   reg_id,
   input  logic              reg_io,
   output logic              reg_ack,
   output logic              reg_err,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [ID_W:0]     req_src,
   input  logic [CMD_W-1:0]  req_cmd,
   output logic [N_EP-1:0]   raise,
   output logic [VEC_W-1:0]  raise_vec,
   output logic              busy,
   output logic              done,
   output logic              err
);
   localparam int SPAN = 1 << ID_W;

   generate
      if (N_EP < 2 || N_EP > SPAN) begin : g_bad_n_ep
         $error("N_EP must lie between 2 and 2**ID_W");
      end
   endgenerate

   logic [SPAN-1:0] pres_span;
   logic            io_set;
   logic [ID_W-1:0] io_id;
   ipi_cmd_t        req_f;
   logic            req_mode_ok;
   logic            fire;
   logic [ID_W-1:0] tgt;

   assign req_ready = !busy;

   ipi_presence_table #(.N_EP(N_EP)) u_table (
      .clk       (clk),
      .rst_n     (rst_n),
      .reg_valid (reg_valid),
      .reg_id    (reg_id),
      .reg_io    (reg_io),
      .reg_ack   (reg_ack),
      .reg_err   (reg_err),
      .pres_span (pres_span),
      .io_set    (io_set),
      .io_id     (io_id)
   );

   ipi_cmd_decode u_decode (
      .cmd     (req_cmd),
      .fields  (req_f),
      .mode_ok (req_mode_ok)
   );

   ipi_fanout #(.N_EP(N_EP)) u_fanout (
      .clk         (clk),
      .rst_n       (rst_n),
      .req_take    (req_valid && req_ready),
      .req_src     (req_src),
      .req_f       (req_f),
      .req_mode_ok (req_mode_ok),
      .pres_span   (pres_span),
      .io_set      (io_set),
      .io_id       (io_id),
      .busy        (busy),
      .fire        (fire),
      .tgt         (tgt),
      .vec         (raise_vec),
      .done        (done),
      .err         (err)
   );

   generate
      for (genvar i = 0; i < N_EP; i++) begin : g_raise
         assign raise[i] = fire && (tgt == ID_W'(i));
      end
   endgenerate
endmodule

// File: rtl/ipi_router_chk.sv
`timescale 1ns/1ps
module ipi_router_chk #(
   parameter int N_EP = 256
) (
   input logic            clk,
   input logic            rst_n,
   input logic            reg_ack,
   input logic            reg_err,
   input logic            req_valid,
   input logic            req_ready,
   input logic [N_EP-1:0] raise,
   input logic            busy,
   input logic            done,
   input logic            err
);
   AST_RAISE_ONEHOT:   assert property (@(posedge clk) disable iff (!rst_n) $onehot0(raise));                    // R5
   AST_REG_EXCLUSIVE:  assert property (@(posedge clk) disable iff (!rst_n) !(reg_ack && reg_err));          // R2
   AST_BUSY_BLOCKS:    assert property (@(posedge clk) disable iff (!rst_n) busy |-> !req_ready);           // R10
   AST_TAKE_GOES_BUSY: assert property (@(posedge clk) disable iff (!rst_n) (req_valid && req_ready) |=> busy); // R10
   AST_ERR_WITH_DONE:  assert property (@(posedge clk) disable iff (!rst_n) err |-> done);                  // R7
   AST_ERR_NO_RAISE:   assert property (@(posedge clk) disable iff (!rst_n) err |-> (raise == '0));         // R7
   AST_RAISE_IN_FLIGHT: assert property (@(posedge clk) disable iff (!rst_n) (|raise) |-> $past(busy));     // R11
   AST_DONE_FREES:     assert property (@(posedge clk) disable iff (!rst_n) done |-> (!busy && req_ready)); // R11
endmodule

bind ipi_router ipi_router_chk #(.N_EP(N_EP)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .reg_ack   (reg_ack),
   .reg_err   (reg_err),
   .req_valid (req_valid),
   .req_ready (req_ready),
   .raise     (raise),
   .busy      (busy),
   .done      (done),
   .err       (err)
);

// File: tb/test_ipi_router.sv
`timescale 1ns/1ps
module test_ipi_router;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_valid = 1'b0;
   logic [7:0]  reg_id = '0;
   logic        reg_io = 1'b0;
   logic        reg_ack, reg_err;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [8:0]  req_src = '0;
   logic [63:0] req_cmd = '0;
   logic [255:0] raise;
   logic [7:0]  raise_vec;
   logic        busy, done, err;

   always #10 clk = ~clk;

   ipi_router i_ipi_router (
      .clk(clk), .rst_n(rst_n), .reg_valid(reg_valid), .reg_id(reg_id), .reg_io(reg_io),
      .reg_ack(reg_ack), .reg_err(reg_err), .req_valid(req_valid), .req_ready(req_ready),
      .req_src(req_src), .req_cmd(req_cmd), .raise(raise), .raise_vec(raise_vec),
      .busy(busy), .done(done), .err(err)
   );

   int     n_run = 0;
   int     n_fail = 0;
   longint cyc = 0;
   bit     pres [256];
   bit     io_set_m = 0;
   int     io_id_m = 0;

   typedef struct {
      bit     is_done;
      int     id;
      int     vec;
      bit     err;
      longint cyc;
      string  rq;
   } ev_t;
   ev_t sbq[$];

   always @(posedge clk) cyc <= cyc + 1;

   task automatic chk(input bit ok, input string rq, input string what, input longint act, input longint exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
      end
   endtask

   function automatic logic [63:0] mk(input int vec, input int mode, input bit logical, input int sh, input int dest);
      logic [63:0] c = '0;
      c[7:0]   = vec[7:0];
      c[10:8]  = mode[2:0];
      c[11]    = logical;
      c[19:18] = sh[1:0];
      c[63:56] = dest[7:0];
      c[40]    = 1'b1; // ignored bit (R3)
      return c;
   endfunction

   task automatic push(input bit d, input int id, input int vec, input bit e, input longint c, input string rq);
      ev_t ev;
      ev.is_done = d; ev.id = id; ev.vec = vec; ev.err = e; ev.cyc = c; ev.rq = rq;
      sbq.push_back(ev);
   endtask

   // expected events from the requirements
   task automatic predict(input int src, input logic [63:0] c, input longint acc, input string rq);
      int  vec = c[7:0];
      int  mode = c[10:8];
      bit  lg = c[11];
      int  sh = c[19:18];
      int  dest = c[63:56];
      bit  src_ep = (src < 256) && pres[src];
      bit  src_io = io_set_m && (src == io_id_m);
      if (!(src_ep || src_io) || (!lg && !pres[dest]) || (sh == 1 && io_set_m && dest == io_id_m)) begin
         push(1, 0, 0, 1, acc + 1, rq);
      end else if (sh < 2) begin
         if ((sh == 1 && !src_ep) || mode > 1) push(1, 0, 0, 1, acc + 1, rq);
         else begin
            push(0, (sh == 1) ? src : dest, vec, 0, acc + 1, rq);
            push(1, 0, 0, 0, acc + 1, rq);
         end
      end else begin
         for (int i = 0; i < 256; i++) begin
            if (pres[i] && (sh == 2 || i != src)) begin
               if (mode > 1) begin
                  push(1, 0, 0, 1, acc + 2 + i, rq);
                  return;
               end
               push(0, i, vec, 0, acc + 2 + i, rq);
            end
         end
         push(1, 0, 0, 0, acc + 257, rq);
      end
   endtask

   // monitor: pop and compare
   always @(negedge clk) begin
      if (rst_n) begin
         if (|raise) begin
            int id = 0;
            ev_t ev;
            for (int i = 0; i < 256; i++) if (raise[i]) id = i;
            if (sbq.size() == 0) chk(0, "R10", "unexpected raise id", id, -1);
            else begin
               ev = sbq.pop_front();
               chk(!ev.is_done, ev.rq, "raise where done expected", id, -1);
               chk(id == ev.id, ev.rq, "raise id", id, ev.id);
               chk(int'(raise_vec) == ev.vec, ev.rq, "raise vector", raise_vec, ev.vec);
               chk(cyc == ev.cyc, "R11", "raise cycle", cyc, ev.cyc);
            end
         end
         if (done) begin
            ev_t ev;
            if (sbq.size() == 0) chk(0, "R10", "unexpected done", 1, 0);
            else begin
               ev = sbq.pop_front();
               chk(ev.is_done, ev.rq, "done where raise expected", 1, 0);
               chk(err == ev.err, ev.rq, "err flag", err, ev.err);
               chk(cyc == ev.cyc, "R11", "done cycle", cyc, ev.cyc);
            end
         end
      end
   end

   task automatic do_reg(input int id, input bit io, input bit exp_err, input string rq);
      @(negedge clk);
      reg_valid = 1; reg_id = id[7:0]; reg_io = io;
      @(negedge clk);
      reg_valid = 0;
      chk(reg_ack == !exp_err, rq, "reg_ack", reg_ack, !exp_err);
      chk(reg_err == exp_err, rq, "reg_err", reg_err, exp_err);
      if (!exp_err) begin
         if (io) begin io_set_m = 1; io_id_m = id; end
         else pres[id] = 1;
      end
   endtask

   task automatic send(input int src, input logic [63:0] c, input string rq);
      @(negedge clk);
      predict(src, c, cyc + 1, rq);
      req_valid = 1; req_src = src[8:0]; req_cmd = c;
      @(negedge clk);
      req_valid = 0;
      chk(busy && !req_ready, "R10", "busy/ready after accept", {busy, req_ready}, 2);
      while (busy) @(negedge clk);
      @(negedge clk);
      chk(sbq.size() == 0, rq, "events left over", sbq.size(), 0);
   endtask

   initial begin
      #(20 * 150000);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R1
      chk(raise == '0, "R1", "raise after reset", raise != '0, 0);
      chk(!busy && req_ready, "R1", "busy/ready after reset", {busy, req_ready}, 1);
      chk(!done && !err && !reg_ack && !reg_err, "R1", "pulses after reset", {done, err, reg_ack, reg_err}, 0);

      // R2
      do_reg(0, 0, 0, "R2");
      do_reg(3, 0, 0, "R2");
      do_reg(5, 0, 0, "R2");
      do_reg(200, 0, 0, "R2");
      do_reg(255, 0, 0, "R2");
      do_reg(3, 0, 1, "R2 duplicate");
      do_reg(9, 1, 0, "R2 io");
      do_reg(12, 1, 1, "R2 second io");

      // R3 / R7 delivered modes
      send(3, mk(8'h41, 0, 0, 0, 5), "R3");
      send(0, mk(8'h99, 1, 0, 0, 200), "R7 lowpri");
      send(9, mk(8'h22, 0, 0, 0, 255), "R3 io sender");
      // R4
      send(5, mk(8'h17, 0, 0, 1, 0), "R4 self");
      send(5, mk(8'h18, 0, 1, 1, 9), "R4 self to io id");
      send(9, mk(8'h19, 0, 1, 1, 0), "R4 self from io");
      // R8
      send(300, mk(8'h30, 0, 0, 0, 5), "R8 src range");
      send(7, mk(8'h31, 0, 0, 0, 5), "R8 src unknown");
      // R9
      send(3, mk(8'h32, 0, 0, 0, 4), "R9 phys unknown");
      send(3, mk(8'h33, 0, 1, 0, 4), "R9 logical");
      // R7 rejected modes
      for (int m = 2; m < 8; m++) send(3, mk(8'h50 + m, m, 0, 0, 5), "R7 bad mode");
      // R5, R6
      send(3, mk(8'hA1, 0, 0, 2, 0), "R5 all");
      send(3, mk(8'hA2, 1, 0, 3, 0), "R6 others");
      send(9, mk(8'hA3, 0, 0, 3, 0), "R6 others from io");
      send(255, mk(8'hA4, 0, 0, 3, 0), "R6 others from 255");
      send(0, mk(8'hA5, 4, 0, 2, 0), "R7 broadcast bad mode");

      // R10: requests during a broadcast are ignored
      @(negedge clk);
      predict(3, mk(8'hB0, 0, 0, 2, 0), cyc + 1, "R10 broadcast");
      req_valid = 1; req_src = 9'd3; req_cmd = mk(8'hB0, 0, 0, 2, 0);
      @(negedge clk);
      req_src = 9'd0; req_cmd = mk(8'hEE, 0, 0, 0, 5);
      for (int k = 0; k < 6; k++) begin
         chk(!req_ready && busy, "R10", "ready while busy", req_ready, 0);
         @(negedge clk);
      end
      req_valid = 0;
      while (busy) @(negedge clk);
      @(negedge clk);
      chk(sbq.size() == 0, "R10", "events left over", sbq.size(), 0);
      chk(raise == '0 && !busy, "R10", "quiet after request", busy, 0);

      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule